// File: doc/BRIEF.md
# Weighted Set-Based Channel Arbiter

This arbiter picks one of sixteen request lines for a multi-channel transfer engine. The channels are split into four groups of four. A three-bit phase counter chooses how the four groups rank on each arbitration. Each phase value has its own group ranking. Under full load, groups 0, 1, 2 and 3 therefore get 4, 2, 1 and 1 grants out of every eight. Inside a group, the four channels take turns.

A grant is registered and held until the consumer pulses `done`. The phase then advances, and a fresh arbitration takes place on the following clock edge.

Top module: `wset_arb`

## Requirements
- R1: While `rst_n` is low and after reset, `gnt` is zero, `gnt_valid` is low and `gnt_id` is zero. The phase starts at 0 and every group pointer starts so that the lowest channel of the group wins first.
- R2: While no grant is held and `req` is all zero, no grant is issued and the phase does not change.
- R3: `gnt` is one-hot or zero. `gnt_valid` is high exactly when `gnt` is non-zero. `gnt_id` is the bit index of the set bit in `gnt`.
- R4: A held grant keeps `gnt`, `gnt_id` and `gnt_valid` unchanged until `done` is sampled high, even if `req` changes.
- R5: When `done` is sampled high with a grant held, the grant clears on that edge and the phase advances by one, wrapping from 7 to 0. The next grant appears one edge later if any request is pending.
- R6: Group g holds channels 4g to 4g+3. For phase p, the group at rank k (0 is the highest rank) is k XOR m, where m is 0 for even p, 1 for p = 1 or 5, 2 for p = 3 and 3 for p = 7. The highest-ranked group with any pending request wins.
- R7: With all sixteen lines requesting, the winning groups repeat as 0,1,0,2,0,1,0,3.
- R8: Each group keeps a pointer to its last granted channel, and the pointer moves only when that group wins. Within the winning group, the search starts at the channel after the pointer and wraps modulo 4.
- R9: With only groups 2 and 3 requesting, the winning group for phases 0 to 7 is 2,3,2,2,2,3,2,3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 16 | Request line per channel |
| done | input | 1 | Service-complete strobe for the held grant |
| gnt | output | 16 | One-hot registered grant |
| gnt_valid | output | 1 | A grant is held |
| gnt_id | output | 4 | Encoded granted channel |

## Verification
The assertions assume a consumer that pulses `done` only while a grant is held. Every stimulus task raises `done` for exactly one cycle, and only after it has seen `gnt_valid` high. The assertions make no assumption about `req`. The bench changes `req` freely in the middle of a hold to show that the held grant ignores it. The bench also sweeps a pseudo-random series of request patterns against an arithmetic model of the phase and the group pointers.

// File: rtl/wset_arb.sv
module wset_arb #(
  parameter int SETS = 4,
  parameter int PER  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SETS*PER-1:0]        req,
  input  logic                       done,
  output logic [SETS*PER-1:0]        gnt,
  output logic                       gnt_valid,
  output logic [$clog2(SETS*PER)-1:0] gnt_id
);
  localparam int CH = SETS * PER;
  localparam int SW = $clog2(SETS);
  localparam int PW = $clog2(PER);
  localparam int IW = $clog2(CH);

  logic [2:0]    phase;
  logic [SW-1:0] xmask;
  logic [SETS-1:0] any;
  logic [PW-1:0] last [SETS];
  logic [PW-1:0] pick [SETS];
  logic [SW-1:0] win_set;
  logic [IW-1:0] win_ch;

  always_comb begin
    case (phase)
      3'd1, 3'd5: xmask = SW'(1);
      3'd3:       xmask = SW'(2);
      3'd7:       xmask = SW'(3);
      default:    xmask = '0;
    endcase
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    assign any[s] = |req[s*PER +: PER];
    always_comb begin
      pick[s] = last[s];
      for (int j = PER; j >= 1; j--)
        if (req[s*PER + int'(PW'(last[s] + PW'(j)))]) pick[s] = PW'(last[s] + PW'(j));
    end
  end

  always_comb begin
    win_set = '0;
    for (int k = SETS - 1; k >= 0; k--)
      if (any[SW'(k) ^ xmask]) win_set = SW'(k) ^ xmask;
  end

  assign win_ch = {win_set, pick[win_set]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt       <= '0;
      gnt_valid <= 1'b0;
      gnt_id    <= '0;
      phase     <= '0;
      for (int s = 0; s < SETS; s++) last[s] <= PW'(PER - 1);
    end else if (gnt_valid) begin
      if (done) begin
        gnt       <= '0;
        gnt_valid <= 1'b0;
        gnt_id    <= '0;
        phase     <= phase + 3'd1;
      end
    end else if (|req) begin
      gnt           <= CH'(1) << win_ch;
      gnt_valid     <= 1'b1;
      gnt_id        <= win_ch;
      last[win_set] <= pick[win_set];
    end
  end
endmodule

module wset_arb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] req,
  input logic        done,
  input logic [15:0] gnt,
  input logic        gnt_valid,
  input logic [3:0]  gnt_id
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_valid_r3:  assert property (@(posedge clk) disable iff (!rst_n) gnt_valid == (gnt != 16'd0));
  p_id_r3:     assert property (@(posedge clk) disable iff (!rst_n) gnt_valid |-> gnt[gnt_id]);
  p_hold_r4:   assert property (@(posedge clk) disable iff (!rst_n)
                 gnt_valid && !done |=> gnt_valid && $stable(gnt) && $stable(gnt_id));
  p_clear_r5:  assert property (@(posedge clk) disable iff (!rst_n) gnt_valid && done |=> !gnt_valid);
  p_idle_r2:   assert property (@(posedge clk) disable iff (!rst_n) !gnt_valid && req == 16'd0 |=> !gnt_valid);
  p_start_r5:  assert property (@(posedge clk) disable iff (!rst_n) !gnt_valid && req != 16'd0 |=> gnt_valid);
  p_req_r6:    assert property (@(posedge clk) disable iff (!rst_n) $rose(gnt_valid) |-> (gnt & $past(req)) != 16'd0);
endmodule

bind wset_arb wset_arb_chk u_chk (.*);

// File: tb/wset_arb_test.sv
module wset_arb_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] req = '0;
  logic done = 1'b0;
  logic [15:0] gnt;
  logic gnt_valid;
  logic [3:0] gnt_id;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  int lp [4];
  bit ended = 0;

  wset_arb uut (.clk(clk), .rst_n(rst_n), .req(req), .done(done),
                .gnt(gnt), .gnt_valid(gnt_valid), .gnt_id(gnt_id));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_ch(input logic [15:0] r);
    int xm, s, idx;
    xm = (ph % 2 == 0) ? 0 : (ph == 3) ? 2 : (ph == 7) ? 3 : 1;
    for (int k = 0; k < 4; k++) begin
      s = k ^ xm;
      if (r[s*4 +: 4] != 4'd0)
        for (int j = 1; j <= 4; j++) begin
          idx = (lp[s] + j) % 4;
          if (r[s*4 + idx]) return s*4 + idx;
        end
    end
    return -1;
  endfunction

  task automatic serve(input string tag, output int ch);
    int e;
    e = model_ch(req);
    @(negedge clk);
    chk(gnt_valid == 1'b1, {tag, " valid"}, gnt_valid, 1);
    chk(int'(gnt_id) == e, {tag, " channel"}, gnt_id, e);
    chk(gnt == (16'd1 << e), "R3 onehot/id", gnt, 1 << e);
    ch = int'(gnt_id);
    if (e >= 0) lp[e/4] = e % 4;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    ph = (ph + 1) % 8;
    chk(gnt_valid == 1'b0 && gnt == 16'd0, "R5 clear after done", gnt_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ch, n;
    logic [15:0] lf;
    for (int s = 0; s < 4; s++) lp[s] = 3;
    repeat (3) @(negedge clk);
    chk(gnt == 16'd0 && !gnt_valid && gnt_id == 4'd0, "R1 reset outputs", gnt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!gnt_valid && gnt == 16'd0, "R2 idle no request", gnt_valid, 0);

    // R7 / R1 / R8: full load
    req = 16'hFFFF;
    for (int g = 0; g < 16; g++) begin
      int es;
      es = (g % 2 == 0) ? 0 : (g % 4 == 1) ? 1 : (g % 8 == 3) ? 2 : 3;
      serve("R8 full load", ch);
      chk(ch / 4 == es, "R7 set pattern", ch / 4, es);
      if (g == 0) chk(ch == 0, "R1 first grant", ch, 0);
    end

    // R4: hold while req changes
    req = 16'h0F00;
    @(negedge clk);
    n = int'(gnt_id);
    for (int c = 0; c < 3; c++) begin
      req = 16'h000F << (4 * c);
      @(negedge clk);
      chk(gnt_valid && int'(gnt_id) == n, "R4 hold", gnt_id, n);
    end
    lp[n/4] = n % 4;
    done = 1'b1; @(negedge clk); done = 1'b0; ph = (ph + 1) % 8;

    // R2: idle does not advance phase
    req = 16'd0;
    repeat (5) @(negedge clk);
    chk(!gnt_valid, "R2 idle gap", gnt_valid, 0);

    // R9: only sets 2 and 3
    req = 16'hFF00;
    for (int g = 0; g < 16; g++) begin
      int es, p;
      p = ph;
      es = (p == 1 || p == 5 || p == 7) ? 3 : 2;
      serve("R6 sets23", ch);
      chk(ch / 4 == es, "R9 set order", ch / 4, es);
    end

    // R8: single set fairness
    req = 16'h00F0;
    for (int g = 0; g < 8; g++) begin
      int prev;
      prev = lp[1];
      serve("R8 rotation", ch);
      chk(ch == 4 + (prev + 1) % 4, "R8 next in set", ch, 4 + (prev + 1) % 4);
    end

    // R6 / R8: pseudo-random sweep
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      req = lf & {lf[7:0], lf[15:8]};
      if (req == 16'd0) begin
        @(negedge clk);
        chk(!gnt_valid, "R2 sweep zero", gnt_valid, 0);
      end else serve("R6 sweep", ch);
    end

    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule